// File: doc/BRIEF.md
# Bit-Reversed Input Sample Loader

This block sits in front of a buffered radix-2 decimation-in-time FFT engine. Complex time-domain samples arrive in natural order over a valid/ready handshake. Each accepted sample is written into the engine's in-place buffer at the address obtained by mirroring the bits of its arrival index. The buffer has separate real and imaginary RAMs. Because the reordering happens while the buffer fills, the engine needs no separate reorder pass.

Once the last of the N samples has been written, the loader issues a one-cycle start pulse to the engine. It then keeps its ready output low, refusing all input, until the engine reports that the transform is finished. It then clears its index and is ready for the next frame at once.

The reversed address for the next arrival is held in a register ahead of time. The RAM write therefore uses a registered address, and no reversal logic sits on the path at write time. The write port is an output of the block, registered one cycle behind the accepting handshake.

Top module: `bitrev_loader`

## Requirements
- R1: After reset, inReady is 1, wrEn is 0 and startPulse is 0.
- R2: A sample is accepted in a cycle where inValid and inReady are both 1. In the next cycle, wrEn is 1 and wrRe and wrIm carry that sample's real and imaginary parts unchanged.
- R3: The k-th sample accepted in a frame (k counted from 0) is written at the address whose bit i equals bit ADDR_W-1-i of k. For ADDR_W=3, index 1 goes to address 4 and index 3 goes to address 6.
- R4: inReady falls in the cycle after the N-th accept of a frame, where N = 2^ADDR_W. It stays low until fftDone is taken.
- R5: startPulse is high for exactly one cycle. That cycle is the one after the write of the last sample, which is two cycles after the N-th accept.
- R6: A sample offered while inReady is 0 is not written, and it does not advance the arrival index.
- R7: fftDone is taken in the start-pulse cycle or in any later cycle while inReady is low. In the cycle after, inReady is 1 and the next accepted sample is written at address 0.
- R8: fftDone asserted while the frame is filling, or before the start pulse, has no effect. The frame still needs N accepts, and the addresses continue in sequence.
- R9: A cycle with inValid low produces no write in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample offered |
| inReady | output | 1 | Loader can take a sample |
| inRe | input | DATA_W | Real part, signed fixed point |
| inIm | input | DATA_W | Imaginary part, signed fixed point |
| wrEn | output | 1 | Buffer write strobe |
| wrAddr | output | ADDR_W | Bit-reversed buffer address |
| wrRe | output | DATA_W | Data for the real RAM |
| wrIm | output | DATA_W | Data for the imaginary RAM |
| startPulse | output | 1 | One-cycle transform start to the engine |
| fftDone | input | 1 | Transform finished, from the engine |

## Verification
The first directed frame streams N samples back to back. It pins the literal addresses 0, 4, 2 and 6, which separates true bit mirroring from a plain or rotated index. Samples offered during the blocked window and an fftDone pulse during filling show whether a refused sample or an early done moves the index or the start timing. Random gaps in inValid, together with fftDone pulses in every phase over many frames, exercise the handshake, the start-pulse position and the restart at address 0 against a bench model of the frame sequence.

// File: rtl/bitrev_loader_pkg.sv
package bitrev_loader_pkg;
  typedef enum logic [1:0] {
    ST_FILL,
    ST_ARM,
    ST_START,
    ST_WAIT
  } ldState_e;

  typedef struct packed {
    logic accept;
    logic clear;
  } ldStrobe_t;
endpackage

// File: rtl/bitrev_loader_dp.sv
module bitrev_loader_dp
  import bitrev_loader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ldStrobe_t         strobe,
  input  logic [DATA_W-1:0] inRe,
  input  logic [DATA_W-1:0] inIm,
  output logic              isLast,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrRe,
  output logic [DATA_W-1:0] wrIm
);
  localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] count;
  logic [ADDR_W-1:0] countNext;
  logic [ADDR_W-1:0] revAddr;
  logic [ADDR_W-1:0] revNext;

  assign countNext = count + 1'b1;
  assign isLast    = (count == LAST_IDX);

  // mirrored form of the next index, prepared before the sample arrives
  for (genvar b = 0; b < ADDR_W; b++) begin : g_rev
    assign revNext[b] = countNext[ADDR_W-1-b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      revAddr <= '0;
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrRe    <= '0;
      wrIm    <= '0;
    end else begin
      wrEn <= strobe.accept;
      if (strobe.accept) begin
        wrAddr  <= revAddr;
        wrRe    <= inRe;
        wrIm    <= inIm;
        count   <= countNext;
        revAddr <= revNext;
      end
      if (strobe.clear) begin
        count   <= '0;
        revAddr <= '0;
      end
    end
  end
endmodule

// File: rtl/bitrev_loader_ctl.sv
module bitrev_loader_ctl
  import bitrev_loader_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      fftDone,
  input  logic      isLast,
  output logic      inReady,
  output logic      startPulse,
  output ldStrobe_t strobe
);
  ldState_e state;
  ldState_e stateNext;

  assign inReady       = (state == ST_FILL);
  assign startPulse    = (state == ST_START);
  assign strobe.accept = inValid && inReady;
  assign strobe.clear  = fftDone && ((state == ST_START) || (state == ST_WAIT));

  always_comb begin
    stateNext = state;
    case (state)
      ST_FILL:  if (strobe.accept && isLast) stateNext = ST_ARM;
      ST_ARM:   stateNext = ST_START;
      ST_START: stateNext = fftDone ? ST_FILL : ST_WAIT;
      ST_WAIT:  if (fftDone) stateNext = ST_FILL;
      default:  stateNext = ST_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FILL;
    else        state <= stateNext;
  end
endmodule

// File: rtl/bitrev_loader.sv
module bitrev_loader
  import bitrev_loader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inRe,
  input  logic [DATA_W-1:0] inIm,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrRe,
  output logic [DATA_W-1:0] wrIm,
  output logic              startPulse,
  input  logic              fftDone
);
  ldStrobe_t strobe;
  logic      isLast;

  bitrev_loader_ctl i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .fftDone    (fftDone),
    .isLast     (isLast),
    .inReady    (inReady),
    .startPulse (startPulse),
    .strobe     (strobe)
  );

  bitrev_loader_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .inRe   (inRe),
    .inIm   (inIm),
    .isLast (isLast),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrRe   (wrRe),
    .wrIm   (wrIm)
  );
endmodule

// File: rtl/bitrev_loader_chk.sv
module bitrev_loader_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inRe,
  input logic [DATA_W-1:0] inIm,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrRe,
  input logic [DATA_W-1:0] wrIm,
  input logic              startPulse,
  input logic              fftDone
);
  logic [ADDR_W-1:0] wrCount;

  function automatic logic [ADDR_W-1:0] mirror(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
    return r;
  endfunction

  // independent tally of writes; wraps once per frame
  always_ff @(posedge clk) begin
    if (!rst_n)    wrCount <= '0;
    else if (wrEn) wrCount <= wrCount + 1'b1;
  end

  AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> wrEn); // R2
  AST_DATA_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> (wrRe == $past(inRe) && wrIm == $past(inIm))); // R2
  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(inValid && inReady) |=> !wrEn); // R6
  AST_ADDR_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (wrAddr == mirror(wrCount))); // R3
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse); // R5
  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> ($past(wrEn) && !inReady && wrCount == '0)); // R5
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inReady && !fftDone) |=> !inReady); // R4
endmodule

bind bitrev_loader bitrev_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_bitrev_loader.sv
module test_bitrev_loader;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          fftDone = 1'b0;
  logic [DW-1:0] inRe = '0;
  logic [DW-1:0] inIm = '0;
  logic          inReady, wrEn, startPulse;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrRe, wrIm;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  // bench model of the frame sequence: 0 fill, 1 last write, 2 start, 3 waiting
  int ph = 0;
  int idx = 0;
  bit expReady = 1'b1, expWrEn = 1'b0, expStart = 1'b0;
  int expAddr = 0, expRe = 0, expIm = 0;

  always #4 clk = ~clk;

  bitrev_loader #(.ADDR_W(AW), .DATA_W(DW)) i_bitrev_loader (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inRe(inRe), .inIm(inIm), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrRe(wrRe), .wrIm(wrIm), .startPulse(startPulse), .fftDone(fftDone)
  );

  function automatic int rev(int i);
    int r = 0;
    for (int b = 0; b < AW; b++) if (i[b]) r |= (1 << (AW - 1 - b));
    return r;
  endfunction

  task automatic chk(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a negedge: apply inputs, advance model, compare at next negedge
  task automatic step(bit v, bit dn, int re, int im);
    bit acc;
    string wtag;
    inValid = v; fftDone = dn; inRe = re[DW-1:0]; inIm = im[DW-1:0];
    acc = v && expReady;
    wtag = !v ? "R9" : (acc ? "R2" : "R6");
    expWrEn = acc;
    if (acc) begin
      expAddr = rev(idx); expRe = re & 16'hFFFF; expIm = im & 16'hFFFF;
    end
    expStart = (ph == 1);
    case (ph)
      0: if (acc) begin
           if (idx == N - 1) begin ph = 1; idx = 0; end
           else idx++;
         end
      1: ph = 2;
      default: if (dn) begin ph = 0; idx = 0; end else ph = 3;
    endcase
    expReady = (ph == 0);
    @(negedge clk);
    chk("R4 inReady", int'(inReady), int'(expReady));
    chk("R5 startPulse", int'(startPulse), int'(expStart));
    chk({wtag, " wrEn"}, int'(wrEn), int'(expWrEn));
    if (expWrEn) begin
      chk("R3 wrAddr", int'(wrAddr), expAddr);
      chk("R2 wrRe", int'(wrRe), expRe);
      chk("R2 wrIm", int'(wrIm), expIm);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nFail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk("R1 inReady", int'(inReady), 1);
    chk("R1 wrEn", int'(wrEn), 0);
    chk("R1 startPulse", int'(startPulse), 0);
    rst_n = 1'b1;

    // directed back-to-back frame with literal address checks
    for (int i = 0; i < N; i++) begin
      step(1'b1, 1'b0, i * 100 + 1, -i);
      if (i == 1) chk("R3 index1", int'(wrAddr), 4);
      if (i == 2) chk("R3 index2", int'(wrAddr), 2);
      if (i == 3) chk("R3 index3", int'(wrAddr), 6);
    end
    // blocked window: samples offered, none written
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 7, 7);
      chk("R6 blocked write", int'(wrEn), 0);
    end
    step(1'b0, 1'b1, 0, 0);
    chk("R7 ready after done", int'(inReady), 1);
    step(1'b1, 1'b0, 16'h1234, 16'h8001);
    chk("R7 restart address", int'(wrAddr), 0);

    // early done pulses during filling are ignored
    for (int i = 1; i < N; i++) begin
      step(1'b1, (i % 2) == 1, i, i + 3);
      if (i == N - 1) chk("R8 start not early", int'(startPulse), 0);
    end
    step(1'b0, 1'b1, 0, 0);
    chk("R8 done before start ignored", int'(inReady), 0);
    step(1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b1, 0, 0);

    // random traffic over many frames
    for (int t = 0; t < 3000; t++) begin
      step(($urandom % 10) < 7, ($urandom % 8) == 0,
           int'($urandom % 65536), int'($urandom % 65536));
    end
    finishRun();
  end
endmodule